// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a small fully associative cache of virtual-to-physical page translations that sits in front of a page table walker. Each slot holds a virtual page number, an address-space tag, a physical frame number, an access-rights code, a valid flag and a pin flag. A lookup compares the presented page number and address-space tag against every slot in parallel. On a match the frame number and a rights verdict for the requested access kind come back combinationally in the same cycle. On no match the block raises a request toward the walker.

The walker returns the translation through a fill port. A fill that names a page and tag already present rewrites that slot in place. Otherwise the fill goes to the lowest free slot, or, when every slot is occupied, to the next unpinned slot in round-robin order. A pin control marks an existing translation as pinned or releases it. Pinned slots are never chosen for replacement and survive every flush. Flushes remove either all unpinned translations of one address space or all unpinned translations. The slot count is a parameter with a default of 64.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only when a valid slot holds both the presented page number and the presented address-space tag. On a hit `lu_hit` is high and `lu_pfn` carries that slot's frame number in the same cycle. Without a hit, `lu_pfn` is zero.
- R2: When `lu_valid` is high and no slot matches, `lu_miss` is high and `lu_hit` is low in the same cycle.
- R3: A lookup of a filled translation hits from the cycle after the fill. A fill whose page and tag are already present rewrites that slot's frame and rights, and no second copy is made.
- R4: When no slot matches the fill and at least one slot is invalid, the fill goes to the lowest-indexed invalid slot, and no valid translation is evicted.
- R5: Rights codes are 0 read-only, 1 read-write, 2 execute-only and 3 no access. Access kinds are 0 read, 1 write, 2 execute and 3 reserved. Read is allowed for codes 0 and 1, write for code 1, and execute for code 2. A hit whose access is not allowed raises `lu_fault`. `lu_fault` is never high without a hit.
- R6: When all slots are valid, the victim is the first unpinned slot at or above a round-robin pointer, wrapping to the lowest unpinned slot. The pointer then moves to the victim index plus one, modulo the slot count. Fills that go to invalid or matching slots leave the pointer unchanged.
- R7: `pn_valid` with `pn_set`=1 pins the slot matching `pn_vpn`/`pn_asid`, and `pn_set`=0 releases it. A fill with `fi_pin`=1 pins its slot. A pinned slot is never replaced and never flushed.
- R8: When no slot matches a fill and every slot is pinned, the fill is dropped and `fi_drop` is high for exactly the following cycle. `fi_drop` is low in every other cycle.
- R9: `fl_valid` with `fl_all`=0 invalidates every unpinned slot whose tag equals `fl_asid`, and other tags are kept. With `fl_all`=1 it invalidates every unpinned slot.
- R10: At most one slot matches any lookup key.
- R11: After reset all slots are invalid and unpinned, the round-robin pointer is 0 and `fi_drop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lu_valid | input | 1 | Lookup request |
| lu_vpn | input | VPN_W | Lookup virtual page number |
| lu_asid | input | ASID_W | Current address-space tag |
| lu_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lu_hit | output | 1 | Translation found |
| lu_miss | output | 1 | Walker request: no translation found |
| lu_pfn | output | PFN_W | Frame number on hit, zero otherwise |
| lu_fault | output | 1 | Hit whose rights forbid the access |
| fi_valid | input | 1 | Fill request from the walker |
| fi_vpn | input | VPN_W | Fill virtual page number |
| fi_asid | input | ASID_W | Fill address-space tag |
| fi_pfn | input | PFN_W | Fill frame number |
| fi_perm | input | 2 | Fill rights code |
| fi_pin | input | 1 | Pin the filled slot |
| fi_drop | output | 1 | Previous-cycle fill dropped (all slots pinned) |
| pn_valid | input | 1 | Pin control request |
| pn_vpn | input | VPN_W | Page number of the slot to pin or release |
| pn_asid | input | ASID_W | Tag of the slot to pin or release |
| pn_set | input | 1 | 1 pins, 0 releases |
| fl_valid | input | 1 | Flush request |
| fl_all | input | 1 | 1 flushes every unpinned slot |
| fl_asid | input | ASID_W | Tag to flush when fl_all is 0 |

## Verification
Lookup results are combinational. The bench drives a lookup just after a rising edge and compares the result at the following falling edge, before any state can change. Fills, pin controls and flushes take effect at the next rising edge, so every lookup that probes their effect is issued in a later cycle. `fi_drop` is registered at the edge that takes the fill and is read one time step after that edge, while it is held for the whole cycle. Round-robin victim order is observed only through which earlier translations start missing after later fills.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [1:0] {
    PERM_RO   = 2'd0,
    PERM_RW   = 2'd1,
    PERM_XO   = 2'd2,
    PERM_NONE = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Rights verdict for one access kind against one rights code.
  function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] acc);
    logic ok;
    ok = 1'b0;
    case (acc_e'(acc))
      ACC_READ:  ok = (perm_e'(perm) == PERM_RO) || (perm_e'(perm) == PERM_RW);
      ACC_WRITE: ok = (perm_e'(perm) == PERM_RW);
      ACC_EXEC:  ok = (perm_e'(perm) == PERM_XO);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/asid_tlb_cam.sv
module asid_tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic                           hit_any,
  output logic [IDX_W-1:0]               hit_idx
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) && (ent_asid[i] == key_asid);
  end

  assign hit_any = |hit_vec;

  // OR-encoder: exact when at most one bit is set.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_wired,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic               free_any,
  output logic [IDX_W-1:0]   free_idx,
  output logic               rr_any,
  output logic [IDX_W-1:0]   rr_idx
);

  // Lowest invalid slot.
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // First unpinned slot at or above the pointer, else lowest unpinned slot.
  always_comb begin
    rr_any = 1'b0;
    rr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_wired[i]) begin
        rr_any = 1'b1;
        rr_idx = IDX_W'(i);
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_wired[i] && (IDX_W'(i) >= rr_ptr)) rr_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lu_valid,
  input  logic [VPN_W-1:0]  lu_vpn,
  input  logic [ASID_W-1:0] lu_asid,
  input  logic [1:0]        lu_acc,
  output logic              lu_hit,
  output logic              lu_miss,
  output logic [PFN_W-1:0]  lu_pfn,
  output logic              lu_fault,
  input  logic              fi_valid,
  input  logic [VPN_W-1:0]  fi_vpn,
  input  logic [ASID_W-1:0] fi_asid,
  input  logic [PFN_W-1:0]  fi_pfn,
  input  logic [1:0]        fi_perm,
  input  logic              fi_pin,
  output logic              fi_drop,
  input  logic              pn_valid,
  input  logic [VPN_W-1:0]  pn_vpn,
  input  logic [ASID_W-1:0] pn_asid,
  input  logic              pn_set,
  input  logic              fl_valid,
  input  logic              fl_all,
  input  logic [ASID_W-1:0] fl_asid
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // Slot state: control bits with reset, payload without reset.
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             wired_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][1:0]        perm_q;
  logic [IDX_W-1:0]               rr_ptr_q;
  logic                           drop_q;

  // Lookup match
  logic [ENTRIES-1:0] lu_vec;
  logic               lu_any;
  logic [IDX_W-1:0]   lu_idx;

  asid_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_lu_cam (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_asid  (asid_q),
    .key_vpn   (lu_vpn),
    .key_asid  (lu_asid),
    .hit_vec   (lu_vec),
    .hit_any   (lu_any),
    .hit_idx   (lu_idx)
  );

  // Fill match (in-place rewrite)
  logic [ENTRIES-1:0] fi_vec;
  logic               fi_any;
  logic [IDX_W-1:0]   fi_idx;

  asid_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_fi_cam (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_asid  (asid_q),
    .key_vpn   (fi_vpn),
    .key_asid  (fi_asid),
    .hit_vec   (fi_vec),
    .hit_any   (fi_any),
    .hit_idx   (fi_idx)
  );

  // Pin control match
  logic [ENTRIES-1:0] pn_vec;
  logic               pn_any;
  logic [IDX_W-1:0]   pn_idx;

  asid_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_pn_cam (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_asid  (asid_q),
    .key_vpn   (pn_vpn),
    .key_asid  (pn_asid),
    .hit_vec   (pn_vec),
    .hit_any   (pn_any),
    .hit_idx   (pn_idx)
  );

  // Victim choice
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic             rr_any;
  logic [IDX_W-1:0] rr_idx;

  asid_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .ent_valid (valid_q),
    .ent_wired (wired_q),
    .rr_ptr    (rr_ptr_q),
    .free_any  (free_any),
    .free_idx  (free_idx),
    .rr_any    (rr_any),
    .rr_idx    (rr_idx)
  );

  logic             fi_do;
  logic             fi_rr;
  logic [IDX_W-1:0] fi_tgt;
  logic [IDX_W-1:0] rr_next;

  always_comb begin
    fi_do   = fi_valid && (fi_any || free_any || rr_any);
    fi_rr   = fi_valid && !fi_any && !free_any && rr_any;
    fi_tgt  = fi_any ? fi_idx : (free_any ? free_idx : rr_idx);
    rr_next = (rr_idx == LAST_IDX) ? '0 : rr_idx + 1'b1;
  end

  // Lookup outputs: same-cycle result
  always_comb begin
    lu_hit   = lu_valid && lu_any;
    lu_miss  = lu_valid && !lu_any;
    lu_pfn   = lu_hit ? pfn_q[lu_idx] : '0;
    lu_fault = lu_hit && !perm_allows(perm_q[lu_idx], lu_acc);
  end

  assign fi_drop = drop_q;

  // Control state. Later statements win: a flush overrides a same-cycle fill.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      wired_q  <= '0;
      rr_ptr_q <= '0;
      drop_q   <= 1'b0;
    end else begin
      drop_q <= fi_valid && !fi_do;
      if (pn_valid && pn_any) wired_q[pn_idx] <= pn_set;
      if (fi_do) begin
        valid_q[fi_tgt] <= 1'b1;
        if (fi_pin) wired_q[fi_tgt] <= 1'b1;
      end
      if (fi_rr) rr_ptr_q <= rr_next;
      if (fl_valid) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (!wired_q[i] && (fl_all || (asid_q[i] == fl_asid))) valid_q[i] <= 1'b0;
        end
      end
    end
  end

  // Payload: write-only on fill, no reset.
  always_ff @(posedge clk) begin
    if (fi_do) begin
      vpn_q[fi_tgt]  <= fi_vpn;
      asid_q[fi_tgt] <= fi_asid;
      pfn_q[fi_tgt]  <= fi_pfn;
      perm_q[fi_tgt] <= fi_perm;
    end
  end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               lu_valid,
  input logic               lu_hit,
  input logic               lu_fault,
  input logic [ENTRIES-1:0] lu_vec,
  input logic [ENTRIES-1:0] fi_vec,
  input logic [ENTRIES-1:0] pn_vec,
  input logic               fi_valid,
  input logic               fl_valid,
  input logic               fi_drop,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] wired_q
);

  AST_ONE_MATCH_LU: assert property (@(posedge clk) disable iff (rst)
    lu_valid |-> $onehot0(lu_vec)); // R10

  AST_ONE_MATCH_KEYS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fi_vec) && $onehot0(pn_vec)); // R10

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    lu_fault |-> lu_hit); // R5

  AST_PINNED_SURVIVE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    fl_valid |=> (($past(wired_q) & ~valid_q) == '0)); // R7

  AST_PINNED_ARE_VALID: assert property (@(posedge clk) disable iff (rst)
    (wired_q & ~valid_q) == '0); // R7

  AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    fi_drop |-> $past(fi_valid && (&wired_q))); // R8

  AST_NO_DROP_WITH_ROOM: assert property (@(posedge clk) disable iff (rst)
    (fi_valid && !(&wired_q)) |=> !fi_drop); // R8

endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lu_valid (lu_valid),
  .lu_hit   (lu_hit),
  .lu_fault (lu_fault),
  .lu_vec   (lu_vec),
  .fi_vec   (fi_vec),
  .pn_vec   (pn_vec),
  .fi_valid (fi_valid),
  .fl_valid (fl_valid),
  .fi_drop  (fi_drop),
  .valid_q  (valid_q),
  .wired_q  (wired_q)
);

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int VPN_W      = 12;
  localparam int ASID_W     = 4;
  localparam int PFN_W      = 12;
  localparam int WATCHDOG   = 200000;

  localparam logic [1:0] P_RO = 2'd0, P_RW = 2'd1, P_XO = 2'd2;
  localparam logic [1:0] A_RD = 2'd0, A_WR = 2'd1, A_EX = 2'd2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lu_valid = 1'b0;
  logic [VPN_W-1:0]  lu_vpn = '0;
  logic [ASID_W-1:0] lu_asid = '0;
  logic [1:0]        lu_acc = '0;
  logic              lu_hit, lu_miss, lu_fault;
  logic [PFN_W-1:0]  lu_pfn;
  logic              fi_valid = 1'b0;
  logic [VPN_W-1:0]  fi_vpn = '0;
  logic [ASID_W-1:0] fi_asid = '0;
  logic [PFN_W-1:0]  fi_pfn = '0;
  logic [1:0]        fi_perm = '0;
  logic              fi_pin = 1'b0;
  logic              fi_drop;
  logic              pn_valid = 1'b0;
  logic [VPN_W-1:0]  pn_vpn = '0;
  logic [ASID_W-1:0] pn_asid = '0;
  logic              pn_set = 1'b0;
  logic              fl_valid = 1'b0;
  logic              fl_all = 1'b0;
  logic [ASID_W-1:0] fl_asid = '0;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    bit               hit;
    logic [PFN_W-1:0] pfn;
    bit               fault;
    string            req;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) dut_i (
    .clk(clk), .rst(rst),
    .lu_valid(lu_valid), .lu_vpn(lu_vpn), .lu_asid(lu_asid), .lu_acc(lu_acc),
    .lu_hit(lu_hit), .lu_miss(lu_miss), .lu_pfn(lu_pfn), .lu_fault(lu_fault),
    .fi_valid(fi_valid), .fi_vpn(fi_vpn), .fi_asid(fi_asid), .fi_pfn(fi_pfn),
    .fi_perm(fi_perm), .fi_pin(fi_pin), .fi_drop(fi_drop),
    .pn_valid(pn_valid), .pn_vpn(pn_vpn), .pn_asid(pn_asid), .pn_set(pn_set),
    .fl_valid(fl_valid), .fl_all(fl_all), .fl_asid(fl_asid)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compare each lookup at the falling edge of its cycle.
  always @(negedge clk) begin
    if (lu_valid) begin
      if (sb_q.size() == 0) begin
        check("R1", "unexpected lookup", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, "hit",   {31'd0, lu_hit},   {31'd0, e.hit});
        check(e.req, "miss",  {31'd0, lu_miss},  {31'd0, !e.hit});
        check(e.req, "pfn",   32'(lu_pfn),       32'(e.hit ? e.pfn : '0));
        check(e.req, "fault", {31'd0, lu_fault}, {31'd0, e.fault});
      end
    end
  end

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic [1:0] acc,
                      input bit eh, input logic [PFN_W-1:0] ep, input bit ef, input string req);
    exp_t e;
    @(posedge clk); #1;
    lu_valid = 1'b1; lu_vpn = v; lu_asid = a; lu_acc = acc;
    e.hit = eh; e.pfn = ep; e.fault = ef; e.req = req;
    sb_q.push_back(e);
    @(posedge clk); #1;
    lu_valid = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic [PFN_W-1:0] p,
                      input logic [1:0] perm, input bit pin, input bit exp_drop, input string req);
    @(posedge clk); #1;
    fi_valid = 1'b1; fi_vpn = v; fi_asid = a; fi_pfn = p; fi_perm = perm; fi_pin = pin;
    @(posedge clk); #1;
    fi_valid = 1'b0; fi_pin = 1'b0;
    check(req, "fi_drop", {31'd0, fi_drop}, {31'd0, exp_drop});
  endtask

  task automatic pin(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input bit set);
    @(posedge clk); #1;
    pn_valid = 1'b1; pn_vpn = v; pn_asid = a; pn_set = set;
    @(posedge clk); #1;
    pn_valid = 1'b0;
  endtask

  task automatic flush(input bit all, input logic [ASID_W-1:0] a);
    @(posedge clk); #1;
    fl_valid = 1'b1; fl_all = all; fl_asid = a;
    @(posedge clk); #1;
    fl_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R11: empty after reset, no drop flag
    check("R11", "fi_drop after reset", {31'd0, fi_drop}, 32'd0);
    look(12'h000, 4'h0, A_RD, 0, '0, 0, "R11");
    look(12'h010, 4'h1, A_RD, 0, '0, 0, "R2");

    // R3/R1/R5: fill then hit with rights checks
    fill(12'h010, 4'h1, 12'h100, P_RO, 0, 0, "R3");
    look(12'h010, 4'h1, A_RD, 1, 12'h100, 0, "R1");
    look(12'h010, 4'h2, A_RD, 0, '0, 0, "R1");
    look(12'h011, 4'h1, A_RD, 0, '0, 0, "R2");
    look(12'h010, 4'h1, A_WR, 1, 12'h100, 1, "R5");
    look(12'h010, 4'h1, A_EX, 1, 12'h100, 1, "R5");
    fill(12'h011, 4'h1, 12'h101, P_RW, 0, 0, "R3");
    look(12'h011, 4'h1, A_WR, 1, 12'h101, 0, "R5");
    look(12'h011, 4'h1, A_EX, 1, 12'h101, 1, "R5");
    fill(12'h012, 4'h2, 12'h102, P_XO, 0, 0, "R3");
    look(12'h012, 4'h2, A_EX, 1, 12'h102, 0, "R5");
    look(12'h012, 4'h2, A_RD, 1, 12'h102, 1, "R5");
    look(12'h012, 4'h2, 2'd3, 1, 12'h102, 1, "R5");

    // R3: rewrite in place
    fill(12'h010, 4'h1, 12'h1AA, P_RW, 0, 0, "R3");
    look(12'h010, 4'h1, A_WR, 1, 12'h1AA, 0, "R3");

    // R9: flush tag 1 only
    flush(0, 4'h1);
    look(12'h010, 4'h1, A_RD, 0, '0, 0, "R9");
    look(12'h011, 4'h1, A_RD, 0, '0, 0, "R9");
    look(12'h012, 4'h2, A_EX, 1, 12'h102, 0, "R9");

    // R4: seven fills go to the seven invalid slots, slot 2 kept
    for (int i = 0; i < 7; i++)
      fill(12'h030 + 12'(i), 4'h3, 12'h200 + 12'(i), P_RO, 0, 0, "R4");
    look(12'h012, 4'h2, A_EX, 1, 12'h102, 0, "R4");
    for (int i = 0; i < 7; i++)
      look(12'h030 + 12'(i), 4'h3, A_RD, 1, 12'h200 + 12'(i), 0, "R4");

    // R7/R6: pin slot 0 (0x030), round-robin skips it
    pin(12'h030, 4'h3, 1);
    fill(12'h040, 4'h3, 12'h300, P_RO, 0, 0, "R6");
    look(12'h031, 4'h3, A_RD, 0, '0, 0, "R6");
    look(12'h030, 4'h3, A_RD, 1, 12'h200, 0, "R7");
    look(12'h040, 4'h3, A_RD, 1, 12'h300, 0, "R6");
    fill(12'h041, 4'h3, 12'h301, P_RO, 0, 0, "R6");
    look(12'h012, 4'h2, A_EX, 0, '0, 0, "R6");
    look(12'h032, 4'h3, A_RD, 1, 12'h202, 0, "R6");
    fill(12'h042, 4'h3, 12'h302, P_RO, 0, 0, "R6");
    look(12'h032, 4'h3, A_RD, 0, '0, 0, "R6");
    look(12'h033, 4'h3, A_RD, 1, 12'h203, 0, "R6");

    // R9/R7: global flush keeps pinned slot
    flush(1, 4'h0);
    look(12'h030, 4'h3, A_RD, 1, 12'h200, 0, "R7");
    look(12'h040, 4'h3, A_RD, 0, '0, 0, "R9");
    look(12'h033, 4'h3, A_RD, 0, '0, 0, "R9");

    // R7: release then flush removes it
    pin(12'h030, 4'h3, 0);
    flush(1, 4'h0);
    look(12'h030, 4'h3, A_RD, 0, '0, 0, "R7");

    // R8: all slots pinned, extra fill dropped
    for (int i = 0; i < ENTRIES; i++)
      fill(12'h050 + 12'(i), 4'h4, 12'h400 + 12'(i), P_RW, 1, 0, "R8");
    fill(12'h060, 4'h4, 12'h4FF, P_RW, 0, 1, "R8");
    check("R8", "fi_drop one cycle", {31'd0, fi_drop}, 32'd1);
    @(posedge clk); #1;
    check("R8", "fi_drop cleared", {31'd0, fi_drop}, 32'd0);
    look(12'h060, 4'h4, A_RD, 0, '0, 0, "R8");
    flush(1, 4'h0);
    look(12'h057, 4'h4, A_WR, 1, 12'h407, 0, "R7");
    look(12'h050, 4'h4, A_RD, 1, 12'h400, 0, "R7");

    repeat (3) @(posedge clk);
    check("R10", "scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end

endmodule